// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

The controller lets an on-chip requester read and write an external asynchronous static RAM of 256K words of 16 bits. A request gives a valid strobe, a write flag, an 18-bit word address, 16 bits of write data and two byte-lane enables. The block turns each request into one pin-level memory cycle lasting `CYCLE_CLKS` clocks, then pulses `req_ready_o` for one clock. For a read, the captured word is on `rsp_rdata_o` during that pulse.

Every memory control pin is active low and comes straight from a flop. The data bus is split into an output word, an output enable and an input word, which the pad ring joins into one tri-state bus. The controller enables its drivers only during write cycles. It keeps the chip deselected whenever no access is in progress. `CYCLE_CLKS` must be at least 3. It must also span the memory's minimum cycle time, 45 ns for the fastest grade, at the chosen clock. The default of 5 gives 50 ns at 100 MHz.

The requester holds its request until it sees ready. On the clock after ready it either removes the request or replaces it with the next one.

Top module: `sram_ctrl`

## Requirements
- R1: A write cycle holds `mem_ce_no` low and `mem_oe_no` high and drives the bus (`mem_dq_oe_o` high) for its whole length. Request enable bit 0 appears inverted on `mem_lb_no` (data bits 7:0) and bit 1 inverted on `mem_ub_no` (data bits 15:8), and only enabled lanes are stored.
- R2: A read cycle holds `mem_ce_no` low, `mem_oe_no` low and `mem_we_no` high, and keeps the bus undriven. The enabled lanes of `rsp_rdata_o` match the stored word.
- R3: `mem_dq_oe_o` is high only while the chip is selected with `mem_oe_no` high, so the controller and the memory never drive the bus in the same cycle.
- R4: After reset and whenever no cycle is in progress, `mem_ce_no`, `mem_we_no`, `mem_oe_no`, `mem_ub_no` and `mem_lb_no` are high, `mem_dq_oe_o` is low and `req_ready_o` is low.
- R5: Address, byte enables and write data are presented one clock before `mem_we_no` falls. They stay constant while it is low and for one clock after it rises, with the chip still selected.
- R6: Every access keeps `mem_ce_no` low for exactly `CYCLE_CLKS` clocks. In a write, `mem_we_no` is low for `CYCLE_CLKS-2` of them.
- R7: `req_ready_o` is a single-clock pulse per request. Counted from the clock in which an idle controller first sees the request, it appears after `CYCLE_CLKS` clocks for a write and after `CYCLE_CLKS+1` clocks for a read. For a read it coincides with the captured data.
- R8: A read is followed by at least two clocks with the chip deselected and the bus undriven, even when the next request is already waiting. A request waiting at the moment of ready is accepted one clock later than from idle.
- R9: A request whose two enable bits are both zero receives ready one clock after it is seen and never pulls `mem_ce_no` low.
- R10: A partial write leaves the disabled lane of the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte-lane enables, bit 0 = low byte |
| req_ready_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Read data, valid with ready after a read |
| mem_addr_o | output | 18 | Memory address pins |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte enable, active low |
| mem_lb_no | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data received from the memory |

## Verification
Two events can land on the same clock: a read completing, with ready and the bus turnaround, and the arrival of the next request, typically a write that wants to drive the bus. The bench provokes this by presenting the write in the very clock where the read's ready is seen. A behavioural memory model flags any cycle in which both sides would drive a lane. The scoreboard expects the write's ready exactly one clock later than from idle, and a later read-back confirms the stored data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_READ
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  function automatic pin_ctl_t ctl_of(seq_state_e s);
    pin_ctl_t c;
    case (s)
      ST_SETUP:  c = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_STROBE: c = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_HOLD:   c = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_READ:   c = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:   c = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CYCLE_CLKS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [LANES-1:0] req_be_i,
  output seq_state_e       state_d_o,
  output logic             accept_o,
  output logic             ready_o,
  output logic             rd_last_o
);
  localparam int unsigned CW       = $clog2(CYCLE_CLKS + 1);
  localparam int unsigned STB_LAST = CYCLE_CLKS - 3;
  localparam int unsigned RD_LAST  = CYCLE_CLKS - 1;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          ready_q;
  logic          stb_last;
  logic          no_lane;

  assign no_lane   = (req_be_i == '0);
  // a pending ready blocks acceptance: guarantees a dead clock after reads
  assign accept_o  = (state_q == ST_IDLE) && req_valid_i && !ready_q;
  assign stb_last  = (state_q == ST_STROBE) && (cnt_q == CW'(STB_LAST));
  assign rd_last_o = (state_q == ST_READ) && (cnt_q == CW'(RD_LAST));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o && !no_lane) state_d = req_write_i ? ST_SETUP : ST_READ;
      end
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (stb_last) state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_IDLE;
      ST_READ:   if (rd_last_o) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
      ready_q <= (accept_o && no_lane) || stb_last || rd_last_o;
    end
  end

  assign state_d_o = state_d;
  assign ready_o   = ready_q;
endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_d_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);
  pin_ctl_t          ctl_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  lane_n_q, lane_n_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign lane_n_d = (state_d_i == ST_IDLE) ? '1 : ~(accept_i ? req_be_i : be_q);

  // every pin is a flop output: no decode glitches reach the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= ctl_of(ST_IDLE);
      lane_n_q <= '1;
      be_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      ctl_q    <= ctl_of(state_d_i);
      lane_n_q <= lane_n_d;
      if (accept_i) begin
        be_q    <= req_be_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = ctl_q.ce_n;
  assign mem_we_no   = ctl_q.we_n;
  assign mem_oe_no   = ctl_q.oe_n;
  assign mem_dq_oe_o = ctl_q.dq_oe;
  assign mem_lb_no   = lane_n_q[0];
  assign mem_ub_no   = lane_n_q[1];
  assign mem_dq_o    = wdata_q;
endmodule

// File: rtl/sram_rdcap.sv
module sram_rdcap
  import sram_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= dq_i;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned CYCLE_CLKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  seq_state_e state_d;
  logic       accept;
  logic       rd_last;

  sram_seq #(.CYCLE_CLKS(CYCLE_CLKS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_be_i   (req_be_i),
    .state_d_o  (state_d),
    .accept_o   (accept),
    .ready_o    (req_ready_o),
    .rd_last_o  (rd_last)
  );

  sram_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .accept_i   (accept),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_be_i   (req_be_i),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_we_no  (mem_we_no),
    .mem_oe_no  (mem_oe_no),
    .mem_ub_no  (mem_ub_no),
    .mem_lb_no  (mem_lb_no),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o)
  );

  sram_rdcap u_rdcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(rd_last),
    .dq_i     (mem_dq_i),
    .rdata_o  (rsp_rdata_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned CYCLE_CLKS = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_ub_no,
  input logic              mem_lb_no,
  input logic [15:0]       mem_dq_o,
  input logic              mem_dq_oe_o
);
  localparam int unsigned CW = $clog2(CYCLE_CLKS + 2);

  logic [CW-1:0] wl_cnt, cl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_cnt <= '0;
      cl_cnt <= '0;
    end else begin
      wl_cnt <= mem_we_no ? '0 : wl_cnt + 1'b1;
      cl_cnt <= mem_ce_no ? '0 : cl_cnt + 1'b1;
    end
  end

  assert_wr_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));

  assert_rd_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_we_no && !mem_dq_oe_o && !(mem_ub_no && mem_lb_no)));

  assert_drive_only_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_ce_no && mem_oe_no));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_we_no && mem_oe_no && mem_ub_no && mem_lb_no && !mem_dq_oe_o));

  assert_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($stable(mem_addr_o) && $stable(mem_ub_no) && $stable(mem_lb_no)
                          && $stable(mem_dq_o) && $past(!mem_ce_no)));

  assert_strobe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |=> ($stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_ub_no)
                    && $stable(mem_lb_no) && !mem_ce_no));

  assert_strobe_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (wl_cnt == CW'(CYCLE_CLKS - 2)));

  assert_cycle_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (cl_cnt == CW'(CYCLE_CLKS)));

  assert_ready_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (mem_ce_no && !mem_dq_oe_o));

  assert_turnaround_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |=> (mem_ce_no && !mem_dq_oe_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_ub_no  (mem_ub_no),
  .mem_lb_no  (mem_lb_no),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int AW = 18;
  localparam int C  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [1:0]    be = '0;
  logic          ready;
  logic [15:0]   rdata;
  logic [AW-1:0] m_addr;
  logic          ce_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0]   dq_o, dq_i;

  always #5 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .CYCLE_CLKS(C)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_write_i(wr), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_be_i(be),
    .req_ready_o(ready), .rsp_rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_ub_no(ub_n), .mem_lb_no(lb_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int clash = 0, undriven = 0;
  bit done = 0, pend_block = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural memory
  logic [15:0] mem [logic [AW-1:0]];
  logic [15:0] shadow [logic [AW-1:0]];
  logic [15:0] mdl_q = '0;
  logic        drv_lo = 1'b0, drv_hi = 1'b0;

  function automatic logic [15:0] mem_rd(logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && !ce_n && !we_n) begin
      logic [15:0] w;
      w = mem_rd(m_addr);
      if (!lb_n) w[7:0]  = dq_o[7:0];
      if (!ub_n) w[15:8] = dq_o[15:8];
      mem[m_addr] = w;
    end
  end

  always @(negedge clk) begin
    drv_lo = !ce_n && !oe_n && we_n && !lb_n;
    drv_hi = !ce_n && !oe_n && we_n && !ub_n;
    mdl_q  = mem_rd(m_addr);
    if (rst_n && dq_oe && (drv_lo || drv_hi)) begin
      clash++;
      $display("FAIL R3 bus clash at cycle %0d: actual %b expected 0", cyc, {drv_hi, drv_lo});
    end
    if (rst_n && !we_n && !dq_oe) undriven++;
  end

  assign dq_i = {drv_hi ? mdl_q[15:8] : 8'h00, drv_lo ? mdl_q[7:0] : 8'h00};

  // scoreboard
  typedef struct {
    bit          is_wr;
    logic [15:0] exp;
    logic [1:0]  be;
    int          start;
    int          lat;
    string       tag;
  } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (rst_n && ready) begin
      if (sb.size() == 0) check(1'b0, "R7", "ready with nothing pending", 32'd1, 32'd0);
      else begin
        item_t it;
        logic [15:0] msk;
        it = sb.pop_front();
        check(cyc - it.start == it.lat, "R7", {it.tag, " ready latency"}, cyc - it.start, it.lat);
        if (!it.is_wr && it.be != 2'b00) begin
          msk = {{8{it.be[1]}}, {8{it.be[0]}}};
          check((rdata & msk) == (it.exp & msk), "R2", {it.tag, " read data"}, rdata & msk, it.exp & msk);
        end
      end
    end
  end

  task automatic do_req(bit w, logic [AW-1:0] a, logic [15:0] d, logic [1:0] b, bit tight, string tag);
    item_t it;
    logic [15:0] cur;
    bit ce_seen;
    cur = shadow.exists(a) ? shadow[a] : 16'h0000;
    if (w) begin
      if (b[0]) cur[7:0]  = d[7:0];
      if (b[1]) cur[15:8] = d[15:8];
      shadow[a] = cur;
    end
    it.is_wr = w; it.exp = cur; it.be = b; it.start = cyc; it.tag = tag;
    it.lat = (b == 2'b00) ? 1 : (w ? C : C + 1);
    if (pend_block) it.lat++;
    sb.push_back(it);
    valid = 1'b1; wr = w; addr = a; wdata = d; be = b;
    ce_seen = 1'b0;
    do begin
      @(negedge clk);
      if (!ce_n) ce_seen = 1'b1;
    end while (!ready);
    valid = 1'b0;
    if (b == 2'b00) check(!ce_seen, "R9", "chip selected for empty request", ce_seen, 0);
    pend_block = tight;
    if (!tight) repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && ub_n && lb_n, "R4", "pins in reset",
          {ce_n, we_n, oe_n, ub_n, lb_n}, 5'h1f);
    check(!dq_oe && !ready, "R4", "bus/ready in reset", {dq_oe, ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ce_n && !dq_oe && !ready, "R4", "idle after reset", {ce_n, dq_oe, ready}, 3'b100);

    do_req(1, 18'h00001, 16'hA5C3, 2'b11, 0, "R1 full write");
    check(mem_rd(18'h00001) == 16'hA5C3, "R1", "stored word", mem_rd(18'h00001), 16'hA5C3);
    do_req(0, 18'h00001, 16'h0000, 2'b11, 0, "R2 full read");
    do_req(1, 18'h00001, 16'hEE77, 2'b01, 0, "R10 low lane write");
    check(mem_rd(18'h00001) == 16'hA577, "R10", "upper lane kept", mem_rd(18'h00001), 16'hA577);
    do_req(0, 18'h00001, 16'h0000, 2'b11, 0, "R10 read after low write");
    do_req(1, 18'h00001, 16'h9911, 2'b10, 0, "R10 high lane write");
    check(mem_rd(18'h00001) == 16'h9977, "R10", "lower lane kept", mem_rd(18'h00001), 16'h9977);
    do_req(0, 18'h00001, 16'h0000, 2'b11, 0, "R10 read after high write");
    do_req(1, 18'h00001, 16'hFFFF, 2'b00, 0, "R9 empty write");
    do_req(0, 18'h00001, 16'h0000, 2'b00, 0, "R9 empty read");
    do_req(0, 18'h00001, 16'h0000, 2'b11, 0, "R9 word untouched");
    do_req(0, 18'h00001, 16'h0000, 2'b10, 0, "R2 high lane read");
    do_req(0, 18'h00001, 16'h0000, 2'b01, 0, "R2 low lane read");
    do_req(1, 18'h00000, 16'h1234, 2'b11, 0, "R1 lowest address");
    do_req(1, 18'h3FFFF, 16'hBEEF, 2'b11, 0, "R1 highest address");
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0, "R2 lowest address");
    do_req(0, 18'h3FFFF, 16'h0000, 2'b11, 0, "R2 highest address");

    // read completion and next write in the same clock
    do_req(0, 18'h3FFFF, 16'h0000, 2'b11, 1, "R8 read then waiting write");
    do_req(1, 18'h00100, 16'hC0DE, 2'b11, 1, "R8 write behind read");
    do_req(0, 18'h00100, 16'h0000, 2'b11, 1, "R8 read behind write");
    do_req(1, 18'h00100, 16'h5A00, 2'b10, 1, "R8 partial write behind read");
    do_req(0, 18'h00100, 16'h0000, 2'b11, 0, "R8 read-back");

    for (int i = 0; i < 8; i++)
      do_req(1, AW'(i * 4097), 16'(i * 16'h1111 + 3), 2'((i % 3) + 1), (i % 2) == 1, "R1 pattern write");
    for (int i = 0; i < 8; i++)
      do_req(0, AW'(i * 4097), 16'h0000, 2'b11, (i % 2) == 0, "R2 pattern read");

    repeat (4) @(negedge clk);
    check(clash == 0, "R3", "bus clash cycles", clash, 0);
    check(undriven == 0, "R1", "write strobe without driver", undriven, 0);
    check(sb.size() == 0, "R7", "requests without ready", sb.size(), 0);
    check(ce_n && !dq_oe, "R4", "idle at end", {ce_n, dq_oe}, 2'b10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule